// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block keeps the architectural state of an eight-deep floating-point register stack. That state is eight 80-bit registers, a 3-bit top pointer, a 16-bit tag word, a control word and a stored status word. Callers see the registers relative to the top pointer. Stack-relative entry ST(i) lives in physical slot (top + i) mod 8, so pushes and pops move only the pointer and never copy data.

An instruction sequencer drives the block one operation set per clock. The operations are push, pop, a write to ST(i) with or without a tag change, a 64-bit packed-integer alias write into a physical register's mantissa, and loads of the control and status words. A software-initialise command and the hardware reset each put the control word, status word, top pointer and tag word into a known state, but they load different values. The hardware reset also clears the register file, while the initialise command leaves it unchanged. Reads of ST(i), the composed status word, the tag word and the invalid-operation mask bit are all combinational.

Top module: `fp_stack_ctrl`

## Requirements
- R1: `rd_data_o` and `rd_tag_o` show the physical slot (top + `rd_idx_i`) mod 8 combinationally, from the current top pointer.
- R2: `tag_word_o` holds the 2-bit tag of physical slot n in bits [2n+1:2n]. A tag value of 3 means empty.
- R3: A push decrements the top pointer modulo 8 (0 becomes 7) and leaves every tag unchanged.
- R4: A pop sets the tag of the slot at the current top to 3 and then increments the top pointer modulo 8.
- R5: A write to ST(`wr_idx_i`) stores the 80-bit value in the mapped slot. When `wr_tag_en_i` is 1 it replaces that slot's tag with `wr_tag_i`. When `wr_tag_en_i` is 0 the tag keeps its old value.
- R6: The initialise command sets the control word to 0x037F, the stored status to 0, the top pointer to 0 and the tag word to 0xFFFF. It leaves register contents unchanged, and every other request made in the same cycle is ignored.
- R7: Hardware reset (`rst_ni` low) sets the control word to 0x0040, the status to 0, the top pointer to 0, the tag word to 0x5555 and all eight registers to zero.
- R8: `status_word_o` equals the stored status word with bits [13:11] replaced by the top pointer.
- R9: An alias write to physical slot `alias_idx_i` sets bits [63:0] to `alias_data_i` and bits [79:64] to 0xFFFF, and leaves the tag unchanged. If an ST(i) write hits the same slot in the same cycle, the ST(i) write takes effect.
- R10: `inv_masked_o` equals bit 0 of the control word.
- R11: When pop, push and write are requested together, they take effect in that order, and the write address uses the top pointer after the pop and push. A pop together with a push therefore leaves the top pointer unchanged and marks the old top slot empty, unless the write hits that slot.
- R12: `ctrl_wr_i` and `stat_wr_i` load the control word and the stored status word on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| init_i | input | 1 | Software-initialise command |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| wr_en_i | input | 1 | Write to ST(wr_idx_i) |
| wr_idx_i | input | 3 | Stack-relative write index |
| wr_data_i | input | 80 | Write value |
| wr_tag_en_i | input | 1 | Replace the tag on write |
| wr_tag_i | input | 2 | Tag to store on write |
| alias_wr_i | input | 1 | Packed-integer alias write |
| alias_idx_i | input | 3 | Physical slot for the alias write |
| alias_data_i | input | 64 | Mantissa value for the alias write |
| ctrl_wr_i | input | 1 | Load the control word |
| ctrl_data_i | input | 16 | Control word value |
| stat_wr_i | input | 1 | Load the stored status word |
| stat_data_i | input | 16 | Status word value |
| rd_idx_i | input | 3 | Stack-relative read index |
| rd_data_o | output | 80 | ST(rd_idx_i) contents |
| rd_tag_o | output | 2 | ST(rd_idx_i) tag |
| tag_word_o | output | 16 | Packed tag word |
| top_o | output | 3 | Top pointer |
| ctrl_word_o | output | 16 | Control word |
| status_word_o | output | 16 | Composed status word |
| inv_masked_o | output | 1 | Invalid-operation mask bit |

## Verification
If the top pointer is wrong, every stack-relative read is wrong at once. It also shows in `status_word_o` bits [13:11] and `top_o` in the cycle right after the faulty edge. A tag error shows in `tag_word_o` after that same single edge. A misrouted write may show only when the affected slot is read, so the bench sweeps all eight read indices every cycle and compares them with a behavioural model. That catches a bad slot, mantissa or exponent no later than one clock after it is written.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int unsigned NUM_REGS  = 8;
  localparam int unsigned IDX_W     = $clog2(NUM_REGS);
  localparam int unsigned MANT_W    = 64;
  localparam int unsigned EXP_W     = 16;
  localparam int unsigned REG_W     = MANT_W + EXP_W;
  localparam int unsigned TAG_W     = 2;
  localparam int unsigned TAGWORD_W = TAG_W * NUM_REGS;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned TOP_LSB   = 11;

  typedef logic [REG_W-1:0]  fpreg_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t CW_INIT   = 16'h037F;
  localparam word_t CW_RESET  = 16'h0040;
  localparam tag_t  TAG_EMPTY = 2'b11;
  localparam tag_t  TAG_RST   = 2'b01;
  localparam logic [EXP_W-1:0] ALIAS_EXP = '1;
endpackage

// File: rtl/fps_ptr.sv
module fps_ptr
  import fps_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic push_i,
  input  logic pop_i,
  input  idx_t wr_idx_i,
  input  idx_t rd_idx_i,
  output idx_t top_q_o,
  output idx_t wr_slot_o,
  output idx_t rd_slot_o
);
  idx_t top_q, top_pop, top_nxt;

  // order: pop, then push; write uses result
  always_comb begin
    top_pop = pop_i  ? idx_t'(top_q + idx_t'(1)) : top_q;
    top_nxt = push_i ? idx_t'(top_pop - idx_t'(1)) : top_pop;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     top_q <= '0;
    else if (init_i) top_q <= '0;
    else             top_q <= top_nxt;
  end

  assign top_q_o   = top_q;
  assign wr_slot_o = idx_t'(top_nxt + wr_idx_i);
  assign rd_slot_o = idx_t'(top_q + rd_idx_i);
endmodule

// File: rtl/fps_tags.sv
module fps_tags
  import fps_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 init_i,
  input  logic                 pop_i,
  input  idx_t                 pop_slot_i,
  input  logic                 wr_en_i,
  input  logic                 wr_tag_en_i,
  input  idx_t                 wr_slot_i,
  input  tag_t                 wr_tag_i,
  input  idx_t                 rd_slot_i,
  output logic [TAGWORD_W-1:0] tag_word_o,
  output tag_t                 rd_tag_o
);
  tag_t tag_q [NUM_REGS];

  for (genvar n = 0; n < NUM_REGS; n++) begin : g_tag
    logic wr_hit, pop_hit;
    assign wr_hit  = wr_en_i && wr_tag_en_i && (wr_slot_i == idx_t'(n));
    assign pop_hit = pop_i && (pop_slot_i == idx_t'(n));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      tag_q[n] <= TAG_RST;
      else if (init_i)  tag_q[n] <= TAG_EMPTY;
      else if (wr_hit)  tag_q[n] <= wr_tag_i;
      else if (pop_hit) tag_q[n] <= TAG_EMPTY;
    end

    assign tag_word_o[n*TAG_W +: TAG_W] = tag_q[n];
  end

  assign rd_tag_o = tag_q[rd_slot_i];
endmodule

// File: rtl/fps_regfile.sv
module fps_regfile
  import fps_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  idx_t              wr_slot_i,
  input  fpreg_t            wr_data_i,
  input  logic              alias_wr_i,
  input  idx_t              alias_idx_i,
  input  logic [MANT_W-1:0] alias_data_i,
  input  idx_t              rd_slot_i,
  output fpreg_t            rd_data_o
);
  fpreg_t reg_q [NUM_REGS];

  for (genvar n = 0; n < NUM_REGS; n++) begin : g_reg
    logic wr_hit, al_hit;
    assign wr_hit = wr_en_i && (wr_slot_i == idx_t'(n));
    assign al_hit = alias_wr_i && (alias_idx_i == idx_t'(n));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     reg_q[n] <= '0;
      else if (wr_hit) reg_q[n] <= wr_data_i;
      else if (al_hit) reg_q[n] <= {ALIAS_EXP, alias_data_i};
    end
  end

  assign rd_data_o = reg_q[rd_slot_i];
endmodule

// File: rtl/fp_stack_ctrl.sv
module fp_stack_ctrl
  import fps_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        push_i,
  input  logic        pop_i,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_idx_i,
  input  logic [79:0] wr_data_i,
  input  logic        wr_tag_en_i,
  input  logic [1:0]  wr_tag_i,
  input  logic        alias_wr_i,
  input  logic [2:0]  alias_idx_i,
  input  logic [63:0] alias_data_i,
  input  logic        ctrl_wr_i,
  input  logic [15:0] ctrl_data_i,
  input  logic        stat_wr_i,
  input  logic [15:0] stat_data_i,
  input  logic [2:0]  rd_idx_i,
  output logic [79:0] rd_data_o,
  output logic [1:0]  rd_tag_o,
  output logic [15:0] tag_word_o,
  output logic [2:0]  top_o,
  output logic [15:0] ctrl_word_o,
  output logic [15:0] status_word_o,
  output logic        inv_masked_o
);
  idx_t  top_q, wr_slot, rd_slot;
  word_t ctrl_q, stat_q;
  logic  pop_g, push_g, wr_g, alias_g;

  // init overrides every other request
  assign pop_g   = pop_i      && !init_i;
  assign push_g  = push_i     && !init_i;
  assign wr_g    = wr_en_i    && !init_i;
  assign alias_g = alias_wr_i && !init_i;

  fps_ptr u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .init_i   (init_i),
    .push_i   (push_g),
    .pop_i    (pop_g),
    .wr_idx_i (wr_idx_i),
    .rd_idx_i (rd_idx_i),
    .top_q_o  (top_q),
    .wr_slot_o(wr_slot),
    .rd_slot_o(rd_slot)
  );

  fps_tags u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (init_i),
    .pop_i      (pop_g),
    .pop_slot_i (top_q),
    .wr_en_i    (wr_g),
    .wr_tag_en_i(wr_tag_en_i),
    .wr_slot_i  (wr_slot),
    .wr_tag_i   (wr_tag_i),
    .rd_slot_i  (rd_slot),
    .tag_word_o (tag_word_o),
    .rd_tag_o   (rd_tag_o)
  );

  fps_regfile u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_g),
    .wr_slot_i   (wr_slot),
    .wr_data_i   (wr_data_i),
    .alias_wr_i  (alias_g),
    .alias_idx_i (alias_idx_i),
    .alias_data_i(alias_data_i),
    .rd_slot_i   (rd_slot),
    .rd_data_o   (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CW_RESET;
      stat_q <= '0;
    end else if (init_i) begin
      ctrl_q <= CW_INIT;
      stat_q <= '0;
    end else begin
      if (ctrl_wr_i) ctrl_q <= ctrl_data_i;
      if (stat_wr_i) stat_q <= stat_data_i;
    end
  end

  always_comb begin
    status_word_o = stat_q;
    status_word_o[TOP_LSB +: IDX_W] = top_q;
  end

  assign top_o        = top_q;
  assign ctrl_word_o  = ctrl_q;
  assign inv_masked_o = ctrl_q[0];
endmodule

// File: rtl/fps_checker.sv
module fps_checker
  import fps_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        init_i,
  input logic        push_i,
  input logic        pop_i,
  input logic        wr_en_i,
  input logic [2:0]  rd_idx_i,
  input logic [2:0]  top_o,
  input logic [15:0] tag_word_o,
  input logic [1:0]  rd_tag_o,
  input logic [15:0] ctrl_word_o,
  input logic [15:0] status_word_o
);
  AST_RD_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_tag_o == tag_word_o[2*int'(idx_t'(top_o + rd_idx_i)) +: 2]); // R1

  AST_PUSH_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !init_i) |=> top_o == idx_t'($past(top_o) - idx_t'(1))); // R3

  AST_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !wr_en_i && !init_i) |=>
      tag_word_o[2*int'($past(top_o)) +: 2] == 2'b11); // R4

  AST_INIT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (ctrl_word_o == 16'h037F && tag_word_o == 16'hFFFF &&
                top_o == '0 && status_word_o == '0)); // R6

  AST_STATUS_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_word_o[13:11] == top_o); // R8
endmodule

bind fp_stack_ctrl fps_checker u_chk (.*);

// File: tb/fp_stack_ctrl_test.sv
`timescale 1ns/1ps
module fp_stack_ctrl_test;
  logic        clk_i = 0, rst_ni = 0;
  logic        init_i = 0, push_i = 0, pop_i = 0, wr_en_i = 0;
  logic [2:0]  wr_idx_i = 0, alias_idx_i = 0, rd_idx_i = 0;
  logic [79:0] wr_data_i = 0;
  logic        wr_tag_en_i = 0, alias_wr_i = 0, ctrl_wr_i = 0, stat_wr_i = 0;
  logic [1:0]  wr_tag_i = 0;
  logic [63:0] alias_data_i = 0;
  logic [15:0] ctrl_data_i = 0, stat_data_i = 0;
  logic [79:0] rd_data_o;
  logic [1:0]  rd_tag_o;
  logic [15:0] tag_word_o, ctrl_word_o, status_word_o;
  logic [2:0]  top_o;
  logic        inv_masked_o;

  int n_chk = 0, n_fail = 0;

  // reference model
  logic [79:0] m_reg [8];
  int          m_tag [8];
  int          m_top;
  logic [15:0] m_ctrl, m_stat;

  always #10 clk_i = ~clk_i;

  fp_stack_ctrl uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic m_reset();
    m_ctrl = 16'h0040; m_stat = 0; m_top = 0;
    for (int k = 0; k < 8; k++) begin m_reg[k] = '0; m_tag[k] = 1; end
  endtask

  task automatic m_clock();
    int t, p;
    if (init_i) begin
      m_ctrl = 16'h037F; m_stat = 0; m_top = 0;
      for (int k = 0; k < 8; k++) m_tag[k] = 3;
      return;
    end
    if (ctrl_wr_i) m_ctrl = ctrl_data_i;
    if (stat_wr_i) m_stat = stat_data_i;
    if (alias_wr_i) m_reg[alias_idx_i] = {16'hFFFF, alias_data_i};
    t = m_top;
    if (pop_i)  begin m_tag[t] = 3; t = (t + 1) % 8; end
    if (push_i) t = (t + 7) % 8;
    if (wr_en_i) begin
      p = (t + wr_idx_i) % 8;
      m_reg[p] = wr_data_i;
      if (wr_tag_en_i) m_tag[p] = wr_tag_i;
    end
    m_top = t;
  endtask

  // full comparison, called at negedge
  task automatic compare(input string req);
    logic [15:0] tw, sw;
    tw = 0;
    for (int k = 0; k < 8; k++) tw[2*k +: 2] = 2'(m_tag[k]);
    sw = (m_stat & ~16'h3800) | (16'(m_top) << 11);
    chk(top_o == 3'(m_top), req, "top", 80'(top_o), 80'(m_top));
    chk(tag_word_o == tw, req, "tag word R2", 80'(tag_word_o), 80'(tw));
    chk(ctrl_word_o == m_ctrl, req, "ctrl R12", 80'(ctrl_word_o), 80'(m_ctrl));
    chk(status_word_o == sw, req, "status R8", 80'(status_word_o), 80'(sw));
    chk(inv_masked_o == m_ctrl[0], req, "inv mask R10", 80'(inv_masked_o), 80'(m_ctrl[0]));
    for (int i = 0; i < 8; i++) begin
      rd_idx_i = 3'(i);
      #1;
      chk(rd_data_o == m_reg[(m_top + i) % 8], req, "read data R1",
          rd_data_o, m_reg[(m_top + i) % 8]);
      chk(rd_tag_o == 2'(m_tag[(m_top + i) % 8]), req, "read tag R1",
          80'(rd_tag_o), 80'(m_tag[(m_top + i) % 8]));
    end
  endtask

  task automatic idle();
    init_i = 0; push_i = 0; pop_i = 0; wr_en_i = 0; wr_tag_en_i = 0;
    alias_wr_i = 0; ctrl_wr_i = 0; stat_wr_i = 0;
  endtask

  task automatic step(input string req);
    @(posedge clk_i);
    m_clock();
    @(negedge clk_i);
    compare(req);
    idle();
  endtask

  task automatic do_write(input int idx, input logic [79:0] d, input bit ten, input int tg);
    wr_en_i = 1; wr_idx_i = 3'(idx); wr_data_i = d; wr_tag_en_i = ten; wr_tag_i = 2'(tg);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m_reset();
    repeat (2) @(negedge clk_i);
    compare("R7 reset");
    rst_ni = 1;
    @(negedge clk_i);
    compare("R7 after release");

    // control / status loads, mask bit
    ctrl_wr_i = 1; ctrl_data_i = 16'h1234; stat_wr_i = 1; stat_data_i = 16'hFFFF;
    step("R12 load");
    ctrl_wr_i = 1; ctrl_data_i = 16'h0001; step("R10 mask set");

    // push wrap: 0 -> 7, then more
    for (int k = 0; k < 9; k++) begin push_i = 1; step("R3 push"); end
    // writes with and without tag
    do_write(0, 80'h1111_2222_3333_4444_5555, 1, 0); step("R5 write tag");
    do_write(3, 80'hAAAA_BBBB_CCCC_DDDD_EEEE, 0, 2); step("R5 write keep tag");
    do_write(7, 80'h0123_4567_89AB_CDEF_0F0F, 1, 2); step("R5 write wrap idx");
    // pops
    for (int k = 0; k < 3; k++) begin pop_i = 1; step("R4 pop"); end
    // pop+push, no write
    pop_i = 1; push_i = 1; step("R11 pop push");
    // pop+push+write onto old top
    pop_i = 1; push_i = 1; do_write(0, 80'h7777_0000_0000_0000_0001, 1, 0);
    step("R11 pop push write");
    // pop+write of ST(1)
    pop_i = 1; do_write(1, 80'h5A5A_0000_0000_0000_0002, 1, 1); step("R11 pop write");
    // alias writes
    alias_wr_i = 1; alias_idx_i = 3'd5; alias_data_i = 64'hDEAD_BEEF_0BAD_F00D;
    step("R9 alias");
    alias_wr_i = 1; alias_idx_i = 3'(m_top); alias_data_i = 64'h1;
    do_write(0, 80'h4242_0000_0000_0000_0042, 0, 0);
    step("R9 alias vs write");
    // init with competing requests
    init_i = 1; push_i = 1; pop_i = 1; do_write(2, 80'hFFFF_FFFF_FFFF_FFFF_FFFF, 1, 0);
    alias_wr_i = 1; alias_idx_i = 3'd1; ctrl_wr_i = 1; ctrl_data_i = 16'h0; stat_wr_i = 1;
    step("R6 init");
    // mixed random traffic
    for (int c = 0; c < 400; c++) begin
      push_i = ($urandom % 3) == 0;
      pop_i  = ($urandom % 3) == 0;
      if (($urandom % 2) == 0) do_write($urandom % 8, {$urandom, $urandom, 16'($urandom)},
                                        1'($urandom), $urandom % 4);
      alias_wr_i = ($urandom % 5) == 0; alias_idx_i = 3'($urandom); alias_data_i = {$urandom, $urandom};
      ctrl_wr_i = ($urandom % 7) == 0; ctrl_data_i = 16'($urandom);
      stat_wr_i = ($urandom % 7) == 0; stat_data_i = 16'($urandom);
      init_i = ($urandom % 37) == 0;
      step("R11 mixed");
    end
    // hardware reset mid-run
    rst_ni = 0; #2; m_reset();
    @(negedge clk_i);
    compare("R7 mid reset");
    rst_ni = 1;
    push_i = 1; step("R3 after reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule